// File: doc/BRIEF.md
# Frequency Acquisition Search Controller

This controller steers the tuning code of a digitally controlled oscillator until the oscillator frequency matches the rate of the incoming data. At the end of each measurement window, an external frequency comparator presents a signed frequency error in ppm, qualified by a valid strobe. The error is defined as oscillator frequency minus data frequency, so a negative value means the oscillator is slow. Code 0 is the lowest tuning point. Raising the code raises the frequency, and the code range spans the full supported data-rate range (10 to 675 Mb/s).

Every acquisition begins by forcing the code to 0. The search then climbs upward in coarse steps. It halves the step whenever a full step would cover more than the remaining error, and it retracts a step that overshoots. Once the error magnitude is within the capture window, the controller declares the frequency acquired. It then freezes the code and leaves the rest of the pull-in to the phase loop. A relock request, raised when the error grows past 1000 ppm or when a lower-harmonic rate change is detected, starts a fresh search from the bottom of the range.

The controller has four states, each named below with the transition that leaves it:
- `ST_IDLE` is the state after reset. It leaves by T_START.
- `ST_FLOOR` holds the code at 0 for one cycle. It leaves by T_ARM to `ST_SEARCH`.
- `ST_SEARCH` leaves by T_CAPTURE to `ST_LOCKED`, or by T_WRAP back to `ST_FLOOR`. While it stays, T_RAISE or T_BACKOFF adjusts the code.
- `ST_LOCKED` leaves by T_RESTART, on either start or relock, to `ST_FLOOR`.

T_RELOCK leads from `ST_FLOOR` and `ST_SEARCH` back to `ST_FLOOR`.

Top module: `fa_search_ctrl`

## Requirements
- R1: After reset, the tuning code is 0, the search-active flag is 0 and the acquired flag is 0.
- R2: A start request seen in the idle or locked state does three things at the next edge: it sets the code to 0, sets the step to INIT_STEP, and raises the active flag while clearing the acquired flag. The cycle that follows is a floor cycle, in which a valid error sample is ignored; the search begins on the cycle after it.
- R3: A relock request seen while floored, searching or locked restarts exactly as in R2. A relock request in the idle state is ignored, and the code and both flags stay unchanged.
- R4: While searching, a valid sample below −LOCK_PPM whose magnitude is at least step × PPM_PER_LSB raises the code by the current step. The search never lowers the code except by the back-off of R6 or the restart of R10.
- R5: When a below-window sample's magnitude is less than step × PPM_PER_LSB, the step is halved first, with a floor of 1. The code is then raised by the new step.
- R6: A valid sample above +LOCK_PPM (an overshoot) lowers the code by the current step, clamped at 0, and halves the step, with a floor of 1. The search stays upward afterward.
- R7: A valid sample with magnitude ≤ LOCK_PPM (default 250) enters the locked state. There the acquired flag is 1, the active flag is 0, and the code is held.
- R8: In the locked state, error samples have no effect on the code or the flags.
- R9: Only samples with the valid strobe high act, and each strobed sample makes at most one adjustment. Cycles without a strobe leave the code unchanged.
- R10: If a raise would carry the code past its maximum (2^CODE_W − 1), the controller instead restarts from code 0 through the floor state, with the step reset to INIT_STEP.
- R11: A start request while floored or searching is ignored and does not disturb the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an acquisition (idle or locked only) |
| relock_i | input | 1 | Loss-of-lock or harmonic event: restart the search |
| err_valid_i | input | 1 | Strobe marking a new per-window error sample |
| err_ppm_i | input | ERR_W | Signed error, oscillator minus data, in ppm |
| tune_code_o | output | CODE_W | Oscillator tuning code, 0 is the lowest frequency |
| search_active_o | output | 1 | High in floor and search states |
| acquired_o | output | 1 | High in the locked state |

## Verification
The bench builds the controller with an 8-bit code, an initial step of 32, 200 ppm per code step and a 250 ppm window. With these values, a full climb from the floor to the wrap point takes only eight strobes, so the R10 restart is reached in a short run. The ppm scale also makes every target code reachable with a unit step, so back-off, step halving and capture all occur on ordinary targets. One run uses an offset error term so that capture happens one code below the target, inside the window but not at zero error.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FLOOR,
        ST_SEARCH,
        ST_LOCKED
    } fa_state_e;

    typedef enum logic [1:0] {
        ACT_CAPTURE,
        ACT_RAISE,
        ACT_BACKOFF,
        ACT_WRAP
    } fa_act_e;

endpackage

// File: rtl/fa_hold_reg.sv
`timescale 1ns/1ps
module fa_hold_reg #(
    parameter int            W       = 8,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= RST_VAL;
        end else if (ld_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/fa_step_plan.sv
`timescale 1ns/1ps
module fa_step_plan
    import fa_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int ERR_W       = 20,
    parameter int PPM_PER_LSB = 200,
    parameter int LOCK_PPM    = 250
) (
    input  logic                     [CODE_W-1:0] code_i,
    input  logic                     [CODE_W-1:0] step_i,
    input  logic signed              [ERR_W-1:0]  err_i,
    output fa_act_e                               act_o,
    output logic                     [CODE_W-1:0] code_o,
    output logic                     [CODE_W-1:0] step_o
);

    localparam int PPM_W  = $clog2(PPM_PER_LSB + 1);
    localparam int PROD_W = CODE_W + PPM_W;
    localparam int CMP_W  = ((ERR_W > PROD_W) ? ERR_W : PROD_W) + 1;

    logic              err_neg;
    logic [ERR_W-1:0]  err_mag;
    logic [CMP_W-1:0]  mag_x;
    logic [CMP_W-1:0]  lim_x;
    logic [PROD_W-1:0] span;
    logic [CMP_W-1:0]  span_x;
    logic              in_win;
    logic              near;
    logic [CODE_W-1:0] half;
    logic [CODE_W-1:0] raise_step;
    logic [CODE_W:0]   sum;

    assign err_neg    = err_i[ERR_W-1];
    assign err_mag    = err_neg ? (~err_i + 1'b1) : err_i;
    assign mag_x      = {{(CMP_W-ERR_W){1'b0}}, err_mag};
    assign lim_x      = CMP_W'(LOCK_PPM);
    assign span       = PROD_W'(step_i) * PROD_W'(PPM_PER_LSB);
    assign span_x     = {{(CMP_W-PROD_W){1'b0}}, span};
    assign in_win     = (mag_x <= lim_x);
    assign near       = (mag_x < span_x);
    assign half       = (step_i > CODE_W'(1)) ? (step_i >> 1) : CODE_W'(1);
    assign raise_step = near ? half : step_i;
    assign sum        = {1'b0, code_i} + {1'b0, raise_step};

    always_comb begin
        act_o  = ACT_CAPTURE;
        code_o = code_i;
        step_o = step_i;
        if (in_win) begin
            act_o = ACT_CAPTURE;
        end else if (!err_neg) begin
            act_o  = ACT_BACKOFF;
            code_o = (code_i >= step_i) ? (code_i - step_i) : '0;
            step_o = half;
        end else if (sum[CODE_W]) begin
            act_o  = ACT_WRAP;
            code_o = '0;
        end else begin
            act_o  = ACT_RAISE;
            code_o = sum[CODE_W-1:0];
            step_o = raise_step;
        end
    end

endmodule

// File: rtl/fa_search_ctrl.sv
`timescale 1ns/1ps
module fa_search_ctrl
    import fa_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int ERR_W       = 20,
    parameter int INIT_STEP   = 64,
    parameter int PPM_PER_LSB = 200,
    parameter int LOCK_PPM    = 250
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic                    relock_i,
    input  logic                    err_valid_i,
    input  logic signed [ERR_W-1:0] err_ppm_i,
    output logic        [CODE_W-1:0] tune_code_o,
    output logic                    search_active_o,
    output logic                    acquired_o
);

    localparam logic [CODE_W-1:0]       STEP_INIT = CODE_W'(INIT_STEP);
    localparam logic signed [ERR_W-1:0] LIM_POS   = ERR_W'(LOCK_PPM);

    fa_state_e         state_q, state_d;
    fa_act_e           plan_act;
    logic [CODE_W-1:0] plan_code, plan_step;
    logic [CODE_W-1:0] step_q;
    logic              code_ld, step_ld;
    logic [CODE_W-1:0] code_d, step_d;

    fa_step_plan #(
        .CODE_W      (CODE_W),
        .ERR_W       (ERR_W),
        .PPM_PER_LSB (PPM_PER_LSB),
        .LOCK_PPM    (LOCK_PPM)
    ) u_plan (
        .code_i (tune_code_o),
        .step_i (step_q),
        .err_i  (err_ppm_i),
        .act_o  (plan_act),
        .code_o (plan_code),
        .step_o (plan_step)
    );

    fa_hold_reg #(.W(CODE_W), .RST_VAL('0)) u_code (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ld_i   (code_ld),
        .d_i    (code_d),
        .q_o    (tune_code_o)
    );

    fa_hold_reg #(.W(CODE_W), .RST_VAL(STEP_INIT)) u_step (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ld_i   (step_ld),
        .d_i    (step_d),
        .q_o    (step_q)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and datapath loads
    always_comb begin
        state_d = state_q;
        code_ld = 1'b0;
        step_ld = 1'b0;
        code_d  = '0;
        step_d  = STEP_INIT;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin                  // T_START
                    state_d = ST_FLOOR;
                    code_ld = 1'b1;
                    step_ld = 1'b1;
                end
            end
            ST_FLOOR: begin
                if (relock_i) begin                 // T_RELOCK
                    state_d = ST_FLOOR;
                    code_ld = 1'b1;
                    step_ld = 1'b1;
                end else begin                      // T_ARM
                    state_d = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (relock_i) begin                 // T_RELOCK
                    state_d = ST_FLOOR;
                    code_ld = 1'b1;
                    step_ld = 1'b1;
                end else if (err_valid_i) begin
                    unique case (plan_act)
                        ACT_CAPTURE: state_d = ST_LOCKED;   // T_CAPTURE
                        ACT_WRAP: begin                     // T_WRAP
                            state_d = ST_FLOOR;
                            code_ld = 1'b1;
                            step_ld = 1'b1;
                        end
                        ACT_RAISE, ACT_BACKOFF: begin       // T_RAISE / T_BACKOFF
                            code_ld = 1'b1;
                            step_ld = 1'b1;
                            code_d  = plan_code;
                            step_d  = plan_step;
                        end
                    endcase
                end
            end
            ST_LOCKED: begin
                if (start_i || relock_i) begin      // T_RESTART
                    state_d = ST_FLOOR;
                    code_ld = 1'b1;
                    step_ld = 1'b1;
                end
            end
        endcase
    end

    // Output decode
    always_comb begin
        search_active_o = 1'b0;
        acquired_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FLOOR:  search_active_o = 1'b1;
            ST_SEARCH: search_active_o = 1'b1;
            ST_LOCKED: acquired_o      = 1'b1;
        endcase
    end

    p_floor_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FLOOR) |-> (tune_code_o == '0));

    p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE && $stable(tune_code_o)));

    p_raise_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEARCH && !relock_i && err_valid_i && err_ppm_i < -LIM_POS)
        |=> (tune_code_o > $past(tune_code_o) || tune_code_o == '0));

    p_backoff_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEARCH && !relock_i && err_valid_i && err_ppm_i > LIM_POS)
        |=> (tune_code_o <= $past(tune_code_o)));

    p_lock_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOCKED && !start_i && !relock_i)
        |=> (acquired_o && $stable(tune_code_o)));

    p_hold_novalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEARCH && !relock_i && !err_valid_i) |=> $stable(tune_code_o));

    p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEARCH && start_i && !relock_i && !err_valid_i)
        |=> (search_active_o && $stable(tune_code_o)));

endmodule

// File: tb/fa_search_ctrl_test.sv
`timescale 1ns/1ps
module fa_search_ctrl_test;

    localparam int CW   = 8;
    localparam int EW   = 20;
    localparam int INIT = 32;
    localparam int PPM  = 200;
    localparam int LOCK = 250;
    localparam int MAXC = (1 << CW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 relock = 1'b0;
    logic                 valid = 1'b0;
    logic signed [EW-1:0] err_ppm = '0;
    logic [CW-1:0]        code;
    logic                 active;
    logic                 acq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // model: 0 idle, 1 floor, 2 search, 3 locked
    int    m_state = 0;
    int    m_code  = 0;
    int    m_step  = INIT;
    string m_tag   = "R1";

    always #10 clk = ~clk;

    fa_search_ctrl #(
        .CODE_W(CW), .ERR_W(EW), .INIT_STEP(INIT),
        .PPM_PER_LSB(PPM), .LOCK_PPM(LOCK)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .relock_i(relock),
        .err_valid_i(valid), .err_ppm_i(err_ppm),
        .tune_code_o(code), .search_active_o(active), .acquired_o(acq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart_model();
        m_state = 1;
        m_code  = 0;
        m_step  = INIT;
    endtask

    // Behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_code = 0; m_step = INIT; m_tag = "R1";
        end else begin
            case (m_state)
                0: begin
                    if (start) begin restart_model(); m_tag = "R2"; end
                    else m_tag = "R3";
                end
                1: begin
                    if (relock) begin restart_model(); m_tag = "R3"; end
                    else begin m_state = 2; m_tag = "R2"; end
                end
                2: begin
                    if (relock) begin restart_model(); m_tag = "R3"; end
                    else if (valid) begin
                        int e, mag, ns;
                        e = err_ppm;
                        mag = (e < 0) ? -e : e;
                        if (mag <= LOCK) begin m_state = 3; m_tag = "R7"; end
                        else if (e > 0) begin
                            m_code = (m_code >= m_step) ? m_code - m_step : 0;
                            m_step = (m_step > 1) ? m_step / 2 : 1;
                            m_tag = "R6";
                        end else begin
                            ns = (mag < m_step * PPM && m_step > 1) ? m_step / 2 : m_step;
                            if (m_code + ns > MAXC) begin restart_model(); m_tag = "R10"; end
                            else begin
                                m_tag = (ns != m_step) ? "R5" : "R4";
                                m_code += ns; m_step = ns;
                            end
                        end
                    end else m_tag = start ? "R11" : "R9";
                end
                default: begin
                    if (start || relock) begin restart_model(); m_tag = "R3"; end
                    else m_tag = "R8";
                end
            endcase
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(code) == m_code, {m_tag, " code"}, int'(code), m_code);
            chk(active == (m_state == 1 || m_state == 2), {m_tag, " active"}, int'(active),
                int'(m_state == 1 || m_state == 2));
            chk(acq == (m_state == 3), {m_tag, " acquired"}, int'(acq), int'(m_state == 3));
        end
    end

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_relock();
        relock = 1'b1; @(negedge clk); relock = 1'b0;
    endtask

    task automatic window(input int target, input int off);
        err_ppm = EW'((int'(code) - target) * PPM + off);
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_search(input int target, input int off, input int limit);
        for (int i = 0; i < limit && !acq; i++) window(target, off);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        int prev;
        bit saw_wrap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(code == 0 && !active && !acq, "R1 reset", int'(code), 0);

        // R3 relock ignored while idle
        pulse_relock();
        chk(code == 0 && !active && !acq, "R3 idle relock", int'(active), 0);

        // R2 start, then floor cycle ignores a sample
        pulse_start();
        chk(active && code == 0, "R2 start floor", int'(active), 1);
        err_ppm = -EW'(30000); valid = 1'b1; @(negedge clk); valid = 1'b0;
        chk(code == 0 && active, "R2 floor ignores sample", int'(code), 0);
        @(negedge clk);

        // R4 R5 R6 R7 search to target 150
        run_search(150, 0, 40);
        chk(acq && !active, "R7 acquired", int'(acq), 1);
        chk(code == 150, "R7 locked code", int'(code), 150);

        // R8 samples ignored while locked
        err_ppm = -EW'(50000); valid = 1'b1; @(negedge clk); valid = 1'b0;
        @(negedge clk);
        chk(code == 150 && acq, "R8 locked hold", int'(code), 150);

        // R3 relock from locked
        pulse_relock();
        chk(code == 0 && active && !acq, "R3 relock restart", int'(code), 0);
        @(negedge clk);

        // R11 start ignored mid-search
        window(200, 0); window(200, 0);
        prev = int'(code);
        pulse_start();
        chk(int'(code) == prev && active, "R11 start ignored", int'(code), prev);
        run_search(200, 0, 40);
        chk(acq && code == 200, "R7 second target", int'(code), 200);

        // R2 start from locked, then R10 wrap on unreachable target
        pulse_start();
        chk(code == 0 && active, "R2 start from locked", int'(code), 0);
        @(negedge clk);
        saw_wrap = 1'b0;
        for (int i = 0; i < 12; i++) begin
            prev = int'(code);
            window(1000, 0);
            if (prev == 224 && code == 0 && active) saw_wrap = 1'b1;
        end
        chk(saw_wrap, "R10 wrap to floor", int'(saw_wrap), 1);

        // R6/R7 offset target, capture inside window off zero error
        pulse_relock();
        @(negedge clk);
        run_search(77, 30, 40);
        prev = (int'(code) - 77) * PPM + 30;
        chk(acq && prev <= LOCK && prev >= -LOCK, "R7 offset capture", prev, 0);
        chk(code == 76, "R6 offset lock code", int'(code), 76);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule